// File: doc/BRIEF.md
# Vertical sync and field detector

This block watches a digitized sync stream and recovers vertical timing from it. Each sample carries a flag that is high while the composite signal sits at sync level, a one-cycle strobe at each detected horizontal sync, and the current horizontal position within the line. The block adds up sync-low samples within a line. When the running total passes a programmable threshold, it emits a one-cycle vertical sync pulse. It classifies the field as odd or even from where in the line that pulse landed.

When vertical sync stops arriving, the block keeps the field indication alternating on its own every 337 line starts. After one or three such missed fields it raises a lost-vsync flag, which asks the timing loops to re-acquire. It also tracks missing horizontal sync. It declares no-video after 16 consecutive line periods without one. The vertical sync and no-video events each raise a maskable, sticky interrupt request that a clear strobe removes.

Top module: `vsync_field_det`

## Requirements
- R1: Out of reset, `vsync`, `field`, `lost_vsync`, `no_video`, `irq_vsync` and `irq_novideo` are all 0.
- R2: Sync-low samples add up across all sync pulses within one line, including serration and equalization pulses. `vsync` is a one-cycle pulse in the cycle after the sample that takes the running total above `cfg_vs_thresh`.
- R3: A sample with `hsync_pulse` high clears the running total and is not counted itself, so ordinary line syncs never build up into a vertical sync.
- R4: `field` is updated in the same cycle `vsync` rises. It becomes 0 (odd) if `hpos` was below `cfg_half_line` at the detecting sample, and 1 (even) otherwise.
- R5: After a detection, no further detection is accepted until LOCKOUT_LINES line starts have passed.
- R6: If FIELD_LINES (337) line starts pass with no detection since the last detection or field boundary, `field` inverts in the cycle after that line start.
- R7: With `cfg_three_fields` = 0, `lost_vsync` rises at the first missed field boundary. With 1, it rises at the third consecutive one. It stays high until the next detected vertical sync clears it, in the same cycle as that `vsync`.
- R8: A window of LINE_CYCLES cycles without `hsync_pulse` counts as a missed line and as a line start. `no_video` rises after the 16th consecutive missed line, and the next `hsync_pulse` clears it.
- R9: `irq_vsync` is set in the cycle `vsync` rises if `cfg_irq_en[0]` is 1. It holds until `irq_ack[0]` clears it in the next cycle; a vertical sync with `cfg_irq_en[0]` = 0 leaves it 0.
- R10: `irq_novideo` is set in the cycle `no_video` rises if `cfg_irq_en[1]` is 1. It stays set after `no_video` clears, until `irq_ack[1]` clears it in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_low | input | 1 | Sample is at sync level |
| hsync_pulse | input | 1 | One-cycle strobe at each detected horizontal sync |
| hpos | input | HPOS_W | Horizontal position within the line |
| cfg_vs_thresh | input | CNT_W | Vertical sync detect threshold in samples |
| cfg_half_line | input | HPOS_W | Position dividing first and second half of a line |
| cfg_three_fields | input | 1 | 0: lost after one missed field, 1: after three |
| cfg_irq_en | input | 2 | Interrupt enables, bit 0 vertical sync, bit 1 no-video |
| irq_ack | input | 2 | Write-one-to-clear strobes, same bit order |
| vsync | output | 1 | Vertical sync pulse |
| field | output | 1 | 0 odd field, 1 even field |
| lost_vsync | output | 1 | Vertical sync lost, re-acquire request |
| no_video | output | 1 | No horizontal sync for 16 lines |
| irq_vsync | output | 1 | Sticky vertical sync interrupt request |
| irq_novideo | output | 1 | Sticky no-video interrupt request |

## Verification
The hardest state to reach is the three-field loss declaration. It needs over a thousand line starts with no detected vertical sync, while the field keeps alternating and the lost flag stays low at the first two boundaries. The bench builds the block with a 32-cycle line but keeps the 337-line field, and it drives whole lines with a model of the line count since the last detection. That model predicts every self-timed field flip and the exact line start at which loss is declared. The lockout window is reached by placing a vertical sync pattern on the line right after a detection.

// File: rtl/vfd_pkg.sv
// Shared constants and types for the vertical sync and field detector.
// Assumes two interrupt sources in a fixed bit order.
package vfd_pkg;
    localparam int NUM_IRQ    = 2;
    localparam int IRQ_VS_BIT = 0;
    localparam int IRQ_NV_BIT = 1;

    typedef enum logic {
        FIELD_ODD  = 1'b0,
        FIELD_EVEN = 1'b1
    } field_e;
endpackage

// File: rtl/vfd_line_timer.sv
// Line timer: produces a line-start tick on every horizontal sync and on
// every LINE_CYCLES-cycle window that passes without one; counts missed
// lines and declares no-video after NOVID_LINES of them in a row.
// Assumes hsync_pulse is a single-cycle strobe.
module vfd_line_timer #(
    parameter int LINE_CYCLES = 1716,
    parameter int NOVID_LINES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_pulse,
    output logic line_tick,
    output logic novid_set,
    output logic no_video
);
    localparam int TMR_W  = $clog2(LINE_CYCLES);
    localparam int MISS_W = $clog2(NOVID_LINES + 1);

    logic [TMR_W-1:0]  tmr_q;
    logic [MISS_W-1:0] miss_q;
    logic              wrap;
    logic              novid_q;

    // A full line window elapsed with no horizontal sync.
    always_comb begin
        wrap      = !hsync_pulse && (tmr_q == TMR_W'(LINE_CYCLES - 1));
        line_tick = hsync_pulse || wrap;
        novid_set = wrap && (miss_q == MISS_W'(NOVID_LINES - 1));
    end

    // Cycle position within the current line window.
    always_ff @(posedge clk) begin
        if (!rst_n || hsync_pulse || wrap) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    // Consecutive missed-line count, saturating at NOVID_LINES.
    always_ff @(posedge clk) begin
        if (!rst_n || hsync_pulse) begin
            miss_q <= '0;
        end else if (wrap && (miss_q != MISS_W'(NOVID_LINES))) begin
            miss_q <= miss_q + 1'b1;
        end
    end

    // No-video flag: set on the last missed line, cleared by a sync.
    always_ff @(posedge clk) begin
        if (!rst_n || hsync_pulse) begin
            novid_q <= 1'b0;
        end else if (novid_set) begin
            novid_q <= 1'b1;
        end
    end

    assign no_video = novid_q;
endmodule

// File: rtl/vfd_vsync_detect.sv
// Vertical sync detector: accumulates sync-low samples within a line and
// flags the sample that takes the total above the threshold, together with
// which half of the line it fell in. Assumes the total clears at each
// horizontal sync, which also excludes that sample from the total.
module vfd_vsync_detect #(
    parameter int CNT_W  = 11,
    parameter int HPOS_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_low,
    input  logic              hsync_pulse,
    input  logic [HPOS_W-1:0] hpos,
    input  logic [CNT_W-1:0]  cfg_thresh,
    input  logic [HPOS_W-1:0] cfg_half,
    input  logic              armed,
    output logic              det,
    output logic              det_even
);
    logic [CNT_W-1:0] low_q;

    // Crossing: this low sample makes the total exceed the threshold.
    always_comb begin
        det      = armed && !hsync_pulse && sync_low && (low_q == cfg_thresh);
        det_even = (hpos >= cfg_half);
    end

    // Saturating sync-low accumulator, cleared per line.
    always_ff @(posedge clk) begin
        if (!rst_n || hsync_pulse) begin
            low_q <= '0;
        end else if (sync_low && (low_q != '1)) begin
            low_q <= low_q + 1'b1;
        end
    end
endmodule

// File: rtl/vfd_field_tracker.sv
// Field tracker: registers the vertical sync pulse and field, counts line
// starts since the last detection, flips the field on its own when a field
// goes by undetected, and declares loss after one or three such fields.
// Also provides the lockout that keeps detection disarmed right after a hit.
module vfd_field_tracker #(
    parameter int FIELD_LINES   = 337,
    parameter int LOCKOUT_LINES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det,
    input  logic det_even,
    input  logic line_tick,
    input  logic cfg_three,
    output logic vsync,
    output logic field,
    output logic lost_vsync,
    output logic armed
);
    import vfd_pkg::*;

    localparam int LCNT_W = $clog2(FIELD_LINES);

    logic [LCNT_W-1:0] lcnt_q;
    logic [1:0]        miss_q;
    logic [1:0]        miss_inc;
    logic [1:0]        need;
    logic              field_end;
    field_e            field_q;
    logic              vsync_q;
    logic              lost_q;

    // Field boundary with no detection, and the loss requirement.
    always_comb begin
        field_end = line_tick && (lcnt_q == LCNT_W'(FIELD_LINES - 1));
        miss_inc  = (miss_q == 2'd3) ? 2'd3 : miss_q + 2'd1;
        need      = cfg_three ? 2'd3 : 2'd1;
        armed     = (lcnt_q >= LCNT_W'(LOCKOUT_LINES)) || (miss_q != 2'd0);
    end

    // Vertical sync pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsync_q <= 1'b0;
        end else begin
            vsync_q <= det;
        end
    end

    // Line count, field state, missed-field count and loss flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcnt_q  <= LCNT_W'(LOCKOUT_LINES);
            miss_q  <= 2'd0;
            field_q <= FIELD_ODD;
            lost_q  <= 1'b0;
        end else if (det) begin
            lcnt_q  <= '0;
            miss_q  <= 2'd0;
            field_q <= det_even ? FIELD_EVEN : FIELD_ODD;
            lost_q  <= 1'b0;
        end else if (field_end) begin
            lcnt_q  <= '0;
            miss_q  <= miss_inc;
            field_q <= (field_q == FIELD_ODD) ? FIELD_EVEN : FIELD_ODD;
            lost_q  <= lost_q || (miss_inc >= need);
        end else if (line_tick) begin
            lcnt_q  <= lcnt_q + 1'b1;
        end
    end

    assign vsync      = vsync_q;
    assign field      = field_q;
    assign lost_vsync = lost_q;
endmodule

// File: rtl/vfd_irq_sticky.sv
// Sticky interrupt requests: each source sets its request when enabled, and
// a one-cycle acknowledge clears it. A set in the same cycle wins.
module vfd_irq_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] en,
    input  logic [N-1:0] ack,
    output logic [N-1:0] pend
);
    for (genvar g = 0; g < N; g++) begin : g_src
        logic req_q;

        // Per-source request bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q <= 1'b0;
            end else if (set[g] && en[g]) begin
                req_q <= 1'b1;
            end else if (ack[g]) begin
                req_q <= 1'b0;
            end
        end

        assign pend[g] = req_q;
    end
endmodule

// File: rtl/vsync_field_det.sv
// Vertical sync and field detector top. Joins the line timer, the sync-low
// accumulator, the field tracker and the interrupt requests. Assumes a
// digitized sync stream with horizontal sync already found upstream.
module vsync_field_det #(
    parameter int HPOS_W        = 11,
    parameter int CNT_W         = 11,
    parameter int LINE_CYCLES   = 1716,
    parameter int NOVID_LINES   = 16,
    parameter int FIELD_LINES   = 337,
    parameter int LOCKOUT_LINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_low,
    input  logic              hsync_pulse,
    input  logic [HPOS_W-1:0] hpos,
    input  logic [CNT_W-1:0]  cfg_vs_thresh,
    input  logic [HPOS_W-1:0] cfg_half_line,
    input  logic              cfg_three_fields,
    input  logic [1:0]        cfg_irq_en,
    input  logic [1:0]        irq_ack,
    output logic              vsync,
    output logic              field,
    output logic              lost_vsync,
    output logic              no_video,
    output logic              irq_vsync,
    output logic              irq_novideo
);
    import vfd_pkg::*;

    logic               line_tick;
    logic               novid_set;
    logic               armed;
    logic               det;
    logic               det_even;
    logic [NUM_IRQ-1:0] irq_set;
    logic [NUM_IRQ-1:0] irq_pend;

    vfd_line_timer #(
        .LINE_CYCLES (LINE_CYCLES),
        .NOVID_LINES (NOVID_LINES)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsync_pulse (hsync_pulse),
        .line_tick   (line_tick),
        .novid_set   (novid_set),
        .no_video    (no_video)
    );

    vfd_vsync_detect #(
        .CNT_W  (CNT_W),
        .HPOS_W (HPOS_W)
    ) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_low    (sync_low),
        .hsync_pulse (hsync_pulse),
        .hpos        (hpos),
        .cfg_thresh  (cfg_vs_thresh),
        .cfg_half    (cfg_half_line),
        .armed       (armed),
        .det         (det),
        .det_even    (det_even)
    );

    vfd_field_tracker #(
        .FIELD_LINES   (FIELD_LINES),
        .LOCKOUT_LINES (LOCKOUT_LINES)
    ) u_field (
        .clk        (clk),
        .rst_n      (rst_n),
        .det        (det),
        .det_even   (det_even),
        .line_tick  (line_tick),
        .cfg_three  (cfg_three_fields),
        .vsync      (vsync),
        .field      (field),
        .lost_vsync (lost_vsync),
        .armed      (armed)
    );

    // Interrupt sources in package bit order.
    always_comb begin
        irq_set             = '0;
        irq_set[IRQ_VS_BIT] = det;
        irq_set[IRQ_NV_BIT] = novid_set;
    end

    vfd_irq_sticky #(
        .N (NUM_IRQ)
    ) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .en    (cfg_irq_en),
        .ack   (irq_ack),
        .pend  (irq_pend)
    );

    assign irq_vsync   = irq_pend[IRQ_VS_BIT];
    assign irq_novideo = irq_pend[IRQ_NV_BIT];
endmodule

// File: rtl/vsync_field_det_chk.sv
// Checker for the vertical sync and field detector, bound to the top.
// Watches ports only.
module vsync_field_det_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hsync_pulse,
    input logic [1:0] cfg_irq_en,
    input logic [1:0] irq_ack,
    input logic       vsync,
    input logic       lost_vsync,
    input logic       no_video,
    input logic       irq_vsync,
    input logic       irq_novideo
);
    AST_VSYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> !vsync); // R5
    AST_LOST_CLEARED_BY_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> !lost_vsync); // R7
    AST_NOVIDEO_ENDS_ON_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_pulse |=> !no_video); // R8
    AST_IRQ_VS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_vsync) |-> (vsync && $past(cfg_irq_en[0]))); // R9
    AST_IRQ_VS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vsync && !irq_ack[0]) |=> irq_vsync); // R9
    AST_IRQ_NV_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_novideo) |-> ($rose(no_video) && $past(cfg_irq_en[1]))); // R10
    AST_IRQ_NV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_novideo && !irq_ack[1]) |=> irq_novideo); // R10
endmodule

bind vsync_field_det vsync_field_det_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsync_pulse (hsync_pulse),
    .cfg_irq_en  (cfg_irq_en),
    .irq_ack     (irq_ack),
    .vsync       (vsync),
    .lost_vsync  (lost_vsync),
    .no_video    (no_video),
    .irq_vsync   (irq_vsync),
    .irq_novideo (irq_novideo)
);

// File: tb/vsync_field_det_test.sv
// Scoreboard bench: the line driver pushes expected items, the monitor
// compares them at the negative clock edge.
module vsync_field_det_test;
    localparam int L    = 32;
    localparam int HW   = 11;
    localparam int CW   = 11;
    localparam int LOCK = 4;
    localparam int FL   = 337;
    localparam int NV   = 16;
    localparam int THR  = 8;
    localparam int HALF = 16;

    localparam int S_FIELD = 0;
    localparam int S_LOST  = 1;
    localparam int S_NOVID = 2;
    localparam int S_IRQVS = 3;
    localparam int S_IRQNV = 4;
    localparam int S_VSYNC = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_low = 1'b0;
    logic          hsync_pulse = 1'b0;
    logic [HW-1:0] hpos = '0;
    logic [CW-1:0] thr = CW'(THR);
    logic [HW-1:0] half = HW'(HALF);
    logic          three = 1'b0;
    logic [1:0]    irq_en = 2'b00;
    logic [1:0]    irq_ack = 2'b00;
    logic          vsync, field, lost_vsync, no_video, irq_vsync, irq_novideo;

    vsync_field_det #(
        .HPOS_W (HW), .CNT_W (CW), .LINE_CYCLES (L),
        .NOVID_LINES (NV), .FIELD_LINES (FL), .LOCKOUT_LINES (LOCK)
    ) uut (
        .clk (clk), .rst_n (rst_n), .sync_low (sync_low),
        .hsync_pulse (hsync_pulse), .hpos (hpos), .cfg_vs_thresh (thr),
        .cfg_half_line (half), .cfg_three_fields (three),
        .cfg_irq_en (irq_en), .irq_ack (irq_ack), .vsync (vsync),
        .field (field), .lost_vsync (lost_vsync), .no_video (no_video),
        .irq_vsync (irq_vsync), .irq_novideo (irq_novideo)
    );

    always #10 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int unsigned at;
        int          sel;
        logic        val;
        int          req;
    } item_t;
    typedef struct {
        int unsigned at;
        logic        even;
    } vs_t;

    item_t exp_q[$];
    vs_t   vs_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // Bench model of the requirements.
    int   lines_since = LOCK;
    int   miss_m = 0;
    logic fld_m = 1'b0;
    logic lost_m = 1'b0;
    logic irqvs_m = 1'b0;
    logic irqnv_m = 1'b0;

    function automatic logic pick(int sel);
        case (sel)
            S_FIELD: return field;
            S_LOST:  return lost_vsync;
            S_NOVID: return no_video;
            S_IRQVS: return irq_vsync;
            S_IRQNV: return irq_novideo;
            default: return vsync;
        endcase
    endfunction

    task automatic push(int unsigned at, int sel, logic val, int req);
        item_t it;
        it.at = at; it.sel = sel; it.val = val; it.req = req;
        exp_q.push_back(it);
    endtask

    // Monitor: vsync stream and queued level checks.
    logic  exp_v;
    item_t mon_it;
    logic  got;
    always @(negedge clk) begin
        if (rst_n) begin
            exp_v = (vs_q.size() > 0) && (vs_q[0].at == cyc);
            if (exp_v || vsync) begin
                n_cmp++;
                if (vsync !== exp_v) begin
                    n_bad++;
                    $display("FAIL R2 vsync at cycle %0d: got %b expected %b", cyc, vsync, exp_v);
                end
            end
            if (exp_v) begin
                n_cmp++;
                if (field !== vs_q[0].even) begin
                    n_bad++;
                    $display("FAIL R4 field at cycle %0d: got %b expected %b", cyc, field, vs_q[0].even);
                end
                void'(vs_q.pop_front());
            end
            while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
                mon_it = exp_q.pop_front();
                n_cmp++;
                got = pick(mon_it.sel);
                if (mon_it.at != cyc || got !== mon_it.val) begin
                    n_bad++;
                    $display("FAIL R%0d sel %0d at cycle %0d: got %b expected %b",
                             mon_it.req, mon_it.sel, cyc, got, mon_it.val);
                end
            end
        end
    end

    // Drives one line of L cycles with up to two sync-low segments.
    // R2 R3 R4 R5 R6 R7 R9 expectations are pushed as the line is driven.
    task automatic drive_line(int s1, int l1, int s2, int l2, logic [1:0] ack);
        int lowc = 0;
        for (int i = 0; i < L; i++) begin
            hsync_pulse = (i == 0);
            hpos        = HW'(i);
            sync_low    = ((i >= s1) && (i < s1 + l1)) || ((i >= s2) && (i < s2 + l2));
            irq_ack     = (i == 5) ? ack : 2'b00;
            if (i == 0) begin
                lowc = 0;                               // R3: hsync sample not counted
                push(cyc + 1, S_NOVID, 1'b0, 8);        // R8: hsync keeps no_video low
                if (lines_since == FL - 1) begin        // R6: self-timed field flip
                    lines_since = 0;
                    fld_m = ~fld_m;
                    miss_m = (miss_m == 3) ? 3 : miss_m + 1;
                    lost_m = (miss_m >= (three ? 3 : 1));
                    push(cyc + 1, S_FIELD, fld_m, 6);
                    push(cyc + 1, S_LOST, lost_m, 7);  // R7
                end else begin
                    lines_since++;
                end
            end else if (sync_low) begin
                if (lowc == THR && (lines_since >= LOCK || miss_m != 0)) begin
                    vs_t ev;
                    ev.at = cyc + 1;
                    ev.even = (i >= HALF);              // R4
                    vs_q.push_back(ev);
                    if (lost_m) push(cyc + 1, S_LOST, 1'b0, 7); // R7 cleared
                    lines_since = 0; miss_m = 0; lost_m = 1'b0; fld_m = ev.even;
                    if (irq_en[0]) irqvs_m = 1'b1;
                    push(cyc + 1, S_IRQVS, irqvs_m, 9); // R9
                end
                lowc++;
            end
            if (i == 4 && ack != 2'b00) begin
                push(cyc + 1, S_IRQVS, irqvs_m, 9);     // R9 sticky
                push(cyc + 1, S_IRQNV, irqnv_m, 10);    // R10 sticky
            end
            if (i == 5) begin
                if (ack[0]) begin irqvs_m = 1'b0; push(cyc + 1, S_IRQVS, 1'b0, 9); end
                if (ack[1]) begin irqnv_m = 1'b0; push(cyc + 1, S_IRQNV, 1'b0, 10); end
            end
            @(negedge clk);
        end
        hsync_pulse = 1'b0;
        sync_low    = 1'b0;
        irq_ack     = 2'b00;
    endtask

    task automatic normal_line();
        drive_line(0, 4, 0, 0, 2'b00);
    endtask
    task automatic odd_vs_line();
        drive_line(2, 10, 0, 0, 2'b00);
    endtask
    task automatic even_vs_line();
        drive_line(2, 5, 20, 8, 2'b00);
    endtask

    initial begin
        int unsigned c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        push(cyc + 1, S_FIELD, 1'b0, 1);
        push(cyc + 1, S_LOST,  1'b0, 1);
        push(cyc + 1, S_NOVID, 1'b0, 1);
        push(cyc + 1, S_IRQVS, 1'b0, 1);
        push(cyc + 1, S_IRQNV, 1'b0, 1);
        push(cyc + 1, S_VSYNC, 1'b0, 1);
        @(negedge clk);

        // R3: ten ordinary lines, 30 low samples total, no vsync
        repeat (10) normal_line();
        // R2 R4: odd detection, interrupt disabled (R9 masked)
        odd_vs_line();
        // R5: pattern inside the lockout window is ignored
        odd_vs_line();
        repeat (2) normal_line();
        // R2 R4: two separated pulses add up, even half of line
        even_vs_line();

        // R9: enabled vertical sync interrupt, then acknowledge
        irq_en = 2'b11;
        repeat (4) normal_line();
        odd_vs_line();
        normal_line();
        drive_line(0, 4, 0, 0, 2'b01);

        // R6 R7: one missed field declares loss
        while (!lost_m) normal_line();
        normal_line();
        odd_vs_line();

        // R6 R7: three missed fields declare loss
        three = 1'b1;
        while (!lost_m) normal_line();
        even_vs_line();

        // R8 R10: sixteen lines without horizontal sync
        repeat (4) normal_line();
        c0 = cyc;
        normal_line();
        push(c0 + 16 * L,     S_NOVID, 1'b0, 8);
        push(c0 + 16 * L + 1, S_NOVID, 1'b1, 8);
        push(c0 + 16 * L + 1, S_IRQNV, 1'b1, 10);
        irqnv_m = 1'b1;
        repeat (16 * L + 8) @(negedge clk);
        normal_line();
        drive_line(0, 4, 0, 0, 2'b10);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0 || vs_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 leftover expectations: got %0d expected 0", exp_q.size() + vs_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog expired: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule